// File: doc/BRIEF.md
# Presettable Two-Section Decade Counter

A four-bit counter built from two count sections with separate count inputs. The low section is one bit that toggles. The upper section is three bits that count modulo five, or modulo eight when a parameter selects the binary variant. Each section advances when its own count input falls. Because each section has its own input, wiring outside the block chooses the counting scheme. If the low bit drives the upper input, the block counts in BCD. If the upper section's top bit drives the low input, the low bit becomes a square wave at one tenth of the input rate with equal high and low times. In the binary variant, the low bit driving the upper input gives a count modulo sixteen.

Two active-low level controls take priority over counting. A clear forces all four bits to zero. A load copies a four-bit data word into the sections. While the load is held low, the outputs follow the data. After the load is released they keep the last value, so the block can also serve as a four-bit latch.

Everything runs on one fast system clock. All six external inputs pass through two-stage synchronizers. A falling edge on a count input is detected when a synchronized 1 is followed by a synchronized 0. A change on an input therefore shows up on `q` at the third rising `clk` edge at which the new level is present.

Top module: `split_decade_counter`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, `q` is 0 after that edge.
- R2: A 1-to-0 transition on `cnt_lo` inverts `q[0]` with the latency stated above. A 0-to-1 transition leaves `q` unchanged.
- R3: With `UPPER_BINARY`=0, each falling edge of `cnt_hi` moves `q[3:1]` (weights 4, 2, 1) one step through 0, 1, 2, 3, 4 and then back to 0. `q[0]` is unaffected.
- R4: With `UPPER_BINARY`=0, if a load leaves `q[3:1]` at 5, 6 or 7, the next falling edge of `cnt_hi` sets `q[3:1]` to 0.
- R5: With `UPPER_BINARY`=1, each falling edge of `cnt_hi` adds one to `q[3:1]` modulo 8.
- R6: While `clear_n` is low, `q` is 0, and count edges have no effect.
- R7: While `clear_n` is high and `load_n` is low, `q` equals `din` and follows each change of `din`. Count edges have no effect.
- R8: After `load_n` returns high, `q` holds the last loaded value while `din` changes.
- R9: When `clear_n` and `load_n` are both low, `q` is 0. Once `clear_n` rises with the load still low, `q` takes `din`.
- R10: With `q[0]` wired to `cnt_hi` and counts applied to `cnt_lo`, `q` steps through 0 to 9 and wraps to 0.
- R11: With `q[3]` wired to `cnt_lo` and counts applied to `cnt_hi`, after n input pulses `q[0]` equals bit 0 of n/5 (integer division) and `q[3:1]` equals n mod 5. This gives five high and five low pulses out of every ten.
- R12: With `UPPER_BINARY`=1 and `q[0]` wired to `cnt_hi`, counts on `cnt_lo` step `q` from 0 to 15 and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the count inputs |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_lo | input | 1 | Count input of the one-bit section, acts on its falling edge |
| cnt_hi | input | 1 | Count input of the three-bit section, acts on its falling edge |
| clear_n | input | 1 | Active-low clear, highest priority after reset |
| load_n | input | 1 | Active-low parallel load of `din` |
| din | input | 4 | Data word for the load |
| q | output | 4 | Counter state, `q[0]` from the low section |

## Verification
The full state of the block is visible on `q`, so a wrong state in either section appears on the port at the third clock edge after its cause and stays there until the next count, load or clear. A fault in the edge detector shows up as a step on a rising input or a missed step on a falling one. A wrong wrap rule in the upper section shows up on the fifth pulse of the chained decade count, or on the first pulse after loading 5, 6 or 7. A priority fault shows up as a nonzero value while clear and load overlap. A bench model that reproduces the input sampling delay is compared with `q` on every clock. This catches any of these faults within one cycle of when it appears.

// File: rtl/sdc_pkg.sv
// Shared constants and types for the split decade counter.
// Assumes a four-bit state split into a 1-bit low section and a 3-bit upper section.
package sdc_pkg;
    localparam int CNT_W       = 4;
    localparam int HI_W        = CNT_W - 1;
    localparam int DECADE_LAST = 4;

    typedef logic [HI_W-1:0] hi_t;

    // Bundle of all asynchronous inputs, synchronized together.
    typedef struct packed {
        logic             cnt_lo;
        logic             cnt_hi;
        logic             clear_n;
        logic             load_n;
        logic [CNT_W-1:0] data;
    } in_bus_t;

    localparam int BUS_W = $bits(in_bus_t);

    // Synchronizer reset image: counts low (no false fall), clear active, load idle.
    localparam in_bus_t BUS_IDLE = '{cnt_lo: 1'b0, cnt_hi: 1'b0, clear_n: 1'b0,
                                     load_n: 1'b1, data: '0};
endpackage

// File: rtl/sdc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is treated independently; reset loads RST_VAL into every stage.
module sdc_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            // Later stages shift the previous stage forward.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdc_fall_det.sv
// Falling-edge detector on already synchronized levels.
// Assumes inputs are stable per clock; a fall is a registered 1 followed by a current 0.
module sdc_fall_det #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    // Remember the previous level of each input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/sdc_lo_stage.sv
// One-bit divide-by-two section.
// Assumes clr_n beats ld_n, which beats adv; all controls already synchronized.
module sdc_lo_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic ld_n,
    input  logic d,
    input  logic adv,
    output logic q
);
    // Apply the priority chain to the single toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= 1'b0;
        else if (!clr_n) q <= 1'b0;
        else if (!ld_n)  q <= d;
        else if (adv)    q <= ~q;
    end
endmodule

// File: rtl/sdc_hi_stage.sv
// Three-bit upper section: modulo five (decade) or modulo eight (binary).
// Assumes clr_n beats ld_n, which beats adv. In decade mode any state at or above
// the last valid value returns to zero on the next advance.
module sdc_hi_stage
    import sdc_pkg::*;
#(
    parameter bit BINARY = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic ld_n,
    input  hi_t  d,
    input  logic adv,
    output hi_t  q
);
    hi_t q_step;

    if (BINARY) begin : g_bin
        // Plain wrap-around increment.
        always_comb q_step = q + hi_t'(1);
    end else begin : g_dec
        // Increment below the last valid state, otherwise return to zero.
        always_comb begin
            if (q >= hi_t'(DECADE_LAST)) q_step = '0;
            else                         q_step = q + hi_t'(1);
        end
    end

    // Apply the priority chain to the upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (!clr_n) q <= '0;
        else if (!ld_n)  q <= d;
        else if (adv)    q <= q_step;
    end
endmodule

// File: rtl/split_decade_counter.sv
// Top level: synchronizes the external inputs, detects falling count edges and
// drives the two count sections. Assumes clk is much faster than every input
// and that inputs hold each level for at least two clk periods.
module split_decade_counter
    import sdc_pkg::*;
#(
    parameter bit UPPER_BINARY = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_lo,
    input  logic             cnt_hi,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic [CNT_W-1:0] din,
    output logic [CNT_W-1:0] q
);
    in_bus_t          raw_bus;
    in_bus_t          bus_s;
    logic [BUS_W-1:0] bus_s_vec;
    logic [1:0]       ticks_s;
    logic [1:0]       falls;
    logic             fall_lo;
    logic             fall_hi;
    logic             clr_n_s;
    logic             ld_n_s;
    logic [CNT_W-1:0] din_s;
    logic             q_lo;
    hi_t              q_hi;

    // Gather raw inputs into one bus for the synchronizer.
    always_comb begin
        raw_bus.cnt_lo  = cnt_lo;
        raw_bus.cnt_hi  = cnt_hi;
        raw_bus.clear_n = clear_n;
        raw_bus.load_n  = load_n;
        raw_bus.data    = din;
    end

    sdc_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (bus_s_vec)
    );

    assign bus_s   = in_bus_t'(bus_s_vec);
    assign ticks_s = {bus_s.cnt_hi, bus_s.cnt_lo};
    assign clr_n_s = bus_s.clear_n;
    assign ld_n_s  = bus_s.load_n;
    assign din_s   = bus_s.data;

    sdc_fall_det #(
        .W       (2),
        .RST_VAL (2'b00)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (ticks_s),
        .fall  (falls)
    );

    assign fall_lo = falls[0];
    assign fall_hi = falls[1];

    sdc_lo_stage u_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n_s),
        .ld_n  (ld_n_s),
        .d     (din_s[0]),
        .adv   (fall_lo),
        .q     (q_lo)
    );

    sdc_hi_stage #(
        .BINARY (UPPER_BINARY)
    ) u_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n_s),
        .ld_n  (ld_n_s),
        .d     (din_s[CNT_W-1:1]),
        .adv   (fall_hi),
        .q     (q_hi)
    );

    assign q = {q_hi, q_lo};
endmodule

// File: rtl/split_decade_counter_chk.sv
// Property checker for split_decade_counter, attached by bind.
// Observes the synchronized controls and detected edges against the state on q.
module split_decade_counter_chk #(
    parameter bit UPPER_BINARY = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] q,
    input logic       clr_n_s,
    input logic       ld_n_s,
    input logic [3:0] din_s,
    input logic       fall_lo,
    input logic       fall_hi
);
    logic counting;
    assign counting = clr_n_s && ld_n_s;

    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> (q == 4'd0));

    assert_clear_over_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n_s && !ld_n_s) |=> (q == 4'd0));

    assert_load_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n_s && !ld_n_s) |=> (q == $past(din_s)));

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !fall_lo && !fall_hi) |=> $stable(q));

    assert_low_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && fall_lo) |=> (q[0] != $past(q[0])));

    if (UPPER_BINARY) begin : g_bin_chk
        assert_upper_mod8_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (counting && fall_hi) |=> (q[3:1] == $past(q[3:1]) + 3'd1));
    end else begin : g_dec_chk
        assert_upper_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (counting && fall_hi && (q[3:1] < 3'd4)) |=> (q[3:1] == $past(q[3:1]) + 3'd1));
        assert_upper_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (counting && fall_hi && (q[3:1] >= 3'd4)) |=> (q[3:1] == 3'd0));
    end
endmodule

bind split_decade_counter split_decade_counter_chk #(
    .UPPER_BINARY (UPPER_BINARY)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .q       (q),
    .clr_n_s (clr_n_s),
    .ld_n_s  (ld_n_s),
    .din_s   (din_s),
    .fall_lo (fall_lo),
    .fall_hi (fall_hi)
);

// File: tb/test_split_decade_counter.sv
module test_split_decade_counter;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 50000;

    typedef struct packed {
        logic       rst;
        logic       lo;
        logic       hi;
        logic       clr;
        logic       ld;
        logic [3:0] d;
    } smp_t;

    localparam smp_t SMP_IDLE = '{rst: 1'b0, lo: 1'b0, hi: 1'b0, clr: 1'b0, ld: 1'b1, d: 4'd0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_lo = 1'b1;
    logic       ext_hi = 1'b1;
    logic       clear_n = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'd0;
    int         mode = 0;   // 0 direct, 1 low bit feeds upper input, 2 top bit feeds low input
    logic [3:0] qd, qb;
    logic       lo_d, hi_d, lo_b, hi_b;
    int         tests = 0;
    int         fails = 0;
    string      phase_req = "R1";
    smp_t       hist_d[$];
    smp_t       hist_b[$];
    logic [3:0] mdl_d = 4'd0;
    logic [3:0] mdl_b = 4'd0;

    // External wiring that selects the counting scheme.
    assign lo_d = (mode == 2) ? qd[3] : ext_lo;
    assign hi_d = (mode == 1) ? qd[0] : ext_hi;
    assign lo_b = (mode == 2) ? qb[3] : ext_lo;
    assign hi_b = (mode == 1) ? qb[0] : ext_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_decade_counter #(.UPPER_BINARY(1'b0)) i_split_decade_counter (
        .clk(clk), .rst_n(rst_n), .cnt_lo(lo_d), .cnt_hi(hi_d),
        .clear_n(clear_n), .load_n(load_n), .din(din), .q(qd));

    split_decade_counter #(.UPPER_BINARY(1'b1)) i_split_decade_counter_bin (
        .clk(clk), .rst_n(rst_n), .cnt_lo(lo_b), .cnt_hi(hi_b),
        .clear_n(clear_n), .load_n(load_n), .din(din), .q(qb));

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q=%0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_next(logic [3:0] s, smp_t o, smp_t c, bit bin);
        logic [3:0] r;
        logic [2:0] h;
        if (!c.clr) return 4'd0;
        if (!c.ld)  return c.d;
        r = s;
        if (o.lo && !c.lo) r[0] = ~r[0];
        if (o.hi && !c.hi) begin
            h = r[3:1];
            if (bin)           h = h + 3'd1;
            else if (h >= 3'd4) h = 3'd0;
            else               h = h + 3'd1;
            r[3:1] = h;
        end
        return r;
    endfunction

    // Reference model: inputs take two clocks to reach the count logic.
    initial begin
        for (int i = 0; i < 4; i++) begin
            hist_d.push_back(SMP_IDLE);
            hist_b.push_back(SMP_IDLE);
        end
    end

    always @(negedge clk) begin
        smp_t nd, nb;
        nd = '{rst: rst_n, lo: lo_d, hi: hi_d, clr: clear_n, ld: load_n, d: din};
        nb = '{rst: rst_n, lo: lo_b, hi: hi_b, clr: clear_n, ld: load_n, d: din};
        if (!hist_d[3].rst) begin
            mdl_d = 4'd0;
            mdl_b = 4'd0;
        end else begin
            mdl_d = ref_next(mdl_d, hist_d[0], hist_d[1], 1'b0);
            mdl_b = ref_next(mdl_b, hist_b[0], hist_b[1], 1'b1);
        end
        check({phase_req, " model/decade"}, qd, mdl_d);
        check({phase_req, " model/binary"}, qb, mdl_b);
        void'(hist_d.pop_front());
        void'(hist_b.pop_front());
        hist_d.push_back(nd);
        hist_b.push_back(nb);
        if (!hist_d[3].rst) begin
            for (int i = 0; i < 3; i++) begin
                hist_d[i] = SMP_IDLE;
                hist_b[i] = SMP_IDLE;
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_lo(input int half);
        ext_lo = 1'b0; cyc(half);
        ext_lo = 1'b1; cyc(half);
    endtask

    task automatic pulse_hi(input int half);
        ext_hi = 1'b0; cyc(half);
        ext_hi = 1'b1; cyc(half);
    endtask

    task automatic load_val(input logic [3:0] v);
        din = v; load_n = 1'b0; cyc(5);
        load_n = 1'b1; cyc(5);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        int ones;
        // R1: reset state
        cyc(4);
        check("R1 reset", qd, 4'd0);
        check("R1 reset bin", qb, 4'd0);
        rst_n = 1'b1; cyc(6);
        check("R1 after release", qd, 4'd0);

        // R7: transparent load, ignores counts
        phase_req = "R7";
        din = 4'd5; load_n = 1'b0; cyc(5);
        check("R7 load 5", qd, 4'd5);
        din = 4'd9; cyc(5);
        check("R7 follows din", qd, 4'd9);
        pulse_lo(5); pulse_hi(5);
        check("R7 counts ignored", qd, 4'd9);

        // R8: hold after release
        phase_req = "R8";
        load_n = 1'b1; cyc(5);
        din = 4'd3; cyc(6);
        check("R8 holds", qd, 4'd9);

        // R2: falling edge toggles, rising does not
        phase_req = "R2";
        ext_lo = 1'b0; cyc(6);
        check("R2 fall toggles", qd, 4'd8);
        ext_lo = 1'b1; cyc(6);
        check("R2 rise ignored", qd, 4'd8);

        // R3/R5: upper section stepping from 4
        phase_req = "R3";
        for (int n = 1; n <= 6; n++) begin
            pulse_hi(5);
            check("R3 decade step", qd, 4'(((4 + n) % 5) * 2));
            check("R5 binary step", qb, 4'(((4 + n) % 8) * 2));
        end

        // R4: illegal upper states recover
        phase_req = "R4";
        for (int v = 10; v <= 15; v++) begin
            load_val(4'(v));
            pulse_hi(5);
            check("R4 recover", qd, 4'(v % 2));
        end

        // R6: clear forces zero, counts ignored
        phase_req = "R6";
        load_val(4'd7);
        clear_n = 1'b0; cyc(5);
        check("R6 clear", qd, 4'd0);
        pulse_lo(5); pulse_hi(5);
        check("R6 counts ignored", qd, 4'd0);

        // R9: clear over load
        phase_req = "R9";
        din = 4'd15; load_n = 1'b0; cyc(6);
        check("R9 clear wins", qd, 4'd0);
        clear_n = 1'b1; cyc(5);
        check("R9 load after clear", qd, 4'd15);
        load_n = 1'b1; cyc(3);

        // R10/R12: low bit drives the upper input
        phase_req = "R10";
        clear_n = 1'b0; cyc(1);
        mode = 1; cyc(6);
        clear_n = 1'b1; cyc(6);
        for (int n = 1; n <= 20; n++) begin
            pulse_lo(8);
            check("R10 BCD count", qd, 4'(n % 10));
            check("R12 modulo-16 count", qb, 4'(n % 16));
        end

        // R11: top bit drives the low input
        phase_req = "R11";
        clear_n = 1'b0; cyc(1);
        mode = 2; cyc(6);
        clear_n = 1'b1; cyc(6);
        ones = 0;
        for (int n = 1; n <= 20; n++) begin
            pulse_hi(8);
            check("R11 square bit", {3'd0, qd[0]}, 4'((n / 5) % 2));
            check("R11 quinary bits", {1'b0, qd[3:1]}, 4'(n % 5));
            if (n <= 10 && qd[0]) ones++;
        end
        check("R11 duty five of ten", 4'(ones), 4'd5);

        mode = 0; cyc(4);
        finish_run();
    end
endmodule